// File: doc/BRIEF.md
# Flash Array Write-Protection Checker

This block decides whether a program or erase request aimed at a 4 MB serial-flash array may go ahead. It reads the protection settings: a 3-bit protect level, a granularity bit, a top/bottom bit and a complement bit. From them it builds a single protected address range. It also works out which bytes a request covers from the start address and the operation size, and then tests the two ranges for overlap.

A request that would touch even one protected byte is refused as a whole. One clock after each request strobe, the block raises either a grant pulse or a reject pulse, never both. The decoded protected range is also driven on output ports, so a status path or a test can observe it.

The block sits between the command decoder of a serial-flash device and its program/erase sequencer. It holds no protection state of its own. The protection bits are presented to it as inputs.

Top module: `wp_guard`

## Requirements
- R1: With protect level 000 and complement 0, no byte is protected: range_valid is 0 and every request is granted.
- R2: With protect level 111 and complement 0, the whole array 000000h–3FFFFFh is protected, whatever the granularity and top/bottom bits are.
- R3: With granularity 0, levels 001 to 110 protect 64 kB, 128 kB, 256 kB, 512 kB, 1 MB and 2 MB, each size double the previous one.
- R4: With top/bottom 0 the region ends at 3FFFFFh. With top/bottom 1 it starts at 000000h.
- R5: With granularity 1, levels 001, 010 and 011 protect 4 kB, 8 kB and 16 kB. Levels 100, 101 and 110 each protect 32 kB.
- R6: With complement 1 the protected range is the rest of the array outside the region named above. Level 000 then protects the whole array, and level 111 protects nothing.
- R7: op selects the span of the request: 0 is a 256-byte page, 1 is a 4 kB sector, 2 is a 64 kB block and 3 is the whole chip. Each span is aligned to its own size. Address bits 23:22 are ignored.
- R8: A request whose span shares at least one byte with the protected range is rejected. Any other request is granted.
- R9: A chip-wide request is rejected whenever any byte is protected.
- R10: Each request cycle yields exactly one pulse, grant or reject, in the cycle after the strobe. No pulse appears without a request, and both pulses are 0 in reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request strobe, one request per high cycle |
| prot_lvl | input | 3 | Protect level |
| gran_sect | input | 1 | Granularity: 1 = 4 kB sector units, 0 = 64 kB block units |
| from_bottom | input | 1 | 1 = region anchored at address 0, 0 = at the top |
| invert | input | 1 | Complement the protection map |
| addr | input | 24 | Start address of the request |
| op | input | 2 | Operation size code (see R7) |
| grant | output | 1 | Pulse: request allowed |
| reject | output | 1 | Pulse: request refused |
| range_valid | output | 1 | A protected range exists |
| range_lo | output | 24 | Lowest protected address (0 when none) |
| range_hi | output | 24 | Highest protected address (0 when none) |

## Verification
A wrong decode of the protection bits shows at once on range_lo, range_hi and range_valid, in the same cycle as the inputs change. A wrong span or overlap test shows one clock later, as a grant where a reject was expected or the other way round. The vectors put request spans one byte inside and one byte outside each range edge, so an off-by-one error in the alignment or in a comparison flips the pulse. Errors in the pulse protocol show as a missing pulse, a doubled pulse or a stray pulse in the cycle after a strobe.

// File: rtl/wp_pkg.sv
package wp_pkg;
  typedef enum logic [1:0] {
    OP_PAGE  = 2'd0,
    OP_SECT  = 2'd1,
    OP_BLOCK = 2'd2,
    OP_CHIP  = 2'd3
  } wp_op_e;

  localparam int PAGE_LG = 8;
  localparam int SECT_LG = 12;
  localparam int BLOCKS_LG = 6;  // 64 blocks in the array

  // log2 of the byte span of one operation; chip handled by caller
  function automatic int span_lg(input wp_op_e op, input int arr_aw);
    case (op)
      OP_PAGE:  return PAGE_LG;
      OP_SECT:  return SECT_LG;
      OP_BLOCK: return arr_aw - BLOCKS_LG;
      default:  return arr_aw;
    endcase
  endfunction

  // log2 of the base protected region for a level 1..6
  function automatic int region_lg(input logic sect_units, input logic [2:0] lvl,
                                   input int arr_aw);
    if (!sect_units)   return arr_aw - BLOCKS_LG + int'(lvl) - 1;
    else if (lvl <= 3) return SECT_LG + int'(lvl) - 1;
    else               return SECT_LG + 3;
  endfunction
endpackage

// File: rtl/wp_region_decode.sv
module wp_region_decode
  import wp_pkg::*;
#(
  parameter int ARR_AW = 22
) (
  input  logic [2:0]        prot_lvl,
  input  logic              gran_sect,
  input  logic              from_bottom,
  input  logic              invert,
  output logic              rg_valid,
  output logic [ARR_AW-1:0] rg_lo,
  output logic [ARR_AW-1:0] rg_hi
);
  localparam logic [ARR_AW:0] ONE  = {{ARR_AW{1'b0}}, 1'b1};
  localparam logic [ARR_AW:0] FULL = ONE << ARR_AW;

  logic            lvl_none, lvl_all;
  logic [ARR_AW:0] sz, base_lo, base_hi, lo_w, hi_w;

  always_comb begin
    lvl_none = (prot_lvl == 3'b000);
    lvl_all  = (prot_lvl == 3'b111);
    sz       = ONE << region_lg(gran_sect, prot_lvl, ARR_AW);
    if (from_bottom) begin
      base_lo = '0;
      base_hi = sz - ONE;
    end else begin
      base_lo = FULL - sz;
      base_hi = FULL - ONE;
    end
    rg_valid = 1'b0;
    lo_w     = '0;
    hi_w     = '0;
    if (!invert) begin
      if (lvl_all) begin
        rg_valid = 1'b1;
        hi_w     = FULL - ONE;
      end else if (!lvl_none) begin
        rg_valid = 1'b1;
        lo_w     = base_lo;
        hi_w     = base_hi;
      end
    end else begin
      if (lvl_none) begin
        rg_valid = 1'b1;
        hi_w     = FULL - ONE;
      end else if (!lvl_all) begin
        rg_valid = 1'b1;
        if (from_bottom) begin
          lo_w = base_hi + ONE;
          hi_w = FULL - ONE;
        end else begin
          hi_w = base_lo - ONE;
        end
      end
    end
    rg_lo = lo_w[ARR_AW-1:0];
    rg_hi = hi_w[ARR_AW-1:0];
  end
endmodule

// File: rtl/wp_req_span.sv
module wp_req_span
  import wp_pkg::*;
#(
  parameter int ARR_AW = 22
) (
  input  logic [ARR_AW-1:0] start,
  input  wp_op_e            op,
  output logic [ARR_AW-1:0] sp_lo,
  output logic [ARR_AW-1:0] sp_hi
);
  localparam logic [ARR_AW-1:0] ONE = {{(ARR_AW-1){1'b0}}, 1'b1};

  logic [ARR_AW-1:0] low_mask;

  always_comb begin
    if (op == OP_CHIP) low_mask = '1;
    else               low_mask = (ONE << span_lg(op, ARR_AW)) - ONE;
    sp_lo = start & ~low_mask;
    sp_hi = start | low_mask;
  end
endmodule

// File: rtl/wp_guard.sv
module wp_guard
  import wp_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int ARR_AW = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [2:0]        prot_lvl,
  input  logic              gran_sect,
  input  logic              from_bottom,
  input  logic              invert,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        op,
  output logic              grant,
  output logic              reject,
  output logic              range_valid,
  output logic [ADDR_W-1:0] range_lo,
  output logic [ADDR_W-1:0] range_hi
);
  localparam int PAD_W = ADDR_W - ARR_AW;

  logic [ARR_AW-1:0] rg_lo, rg_hi, sp_lo, sp_hi;
  logic              rg_valid, overlap;
  wp_op_e            op_e;

  assign op_e = wp_op_e'(op);

  wp_region_decode #(.ARR_AW(ARR_AW)) u_region (
    .prot_lvl   (prot_lvl),
    .gran_sect  (gran_sect),
    .from_bottom(from_bottom),
    .invert     (invert),
    .rg_valid   (rg_valid),
    .rg_lo      (rg_lo),
    .rg_hi      (rg_hi)
  );

  wp_req_span #(.ARR_AW(ARR_AW)) u_span (
    .start(addr[ARR_AW-1:0]),
    .op   (op_e),
    .sp_lo(sp_lo),
    .sp_hi(sp_hi)
  );

  // named overlap event between the two decoded ranges
  assign overlap = rg_valid && (sp_lo <= rg_hi) && (sp_hi >= rg_lo);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant  <= 1'b0;
      reject <= 1'b0;
    end else begin
      grant  <= req && !overlap;
      reject <= req && overlap;
    end
  end

  assign range_valid = rg_valid;
  assign range_lo    = {{PAD_W{1'b0}}, rg_lo};
  assign range_hi    = {{PAD_W{1'b0}}, rg_hi};

  AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> (grant ^ reject)); // R10
  AST_NO_STRAY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (grant || reject) |-> $past(req)); // R10
  AST_EMPTY_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !range_valid) |=> grant); // R1
  AST_FULL_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
    (req && prot_lvl == 3'b111 && !invert) |=> reject); // R2
  AST_CHIP_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
    (req && op == 2'd3 && range_valid) |=> reject); // R9
  AST_RANGE_ORDERED: assert property (@(posedge clk) disable iff (!rst_n)
    range_valid |-> (range_lo <= range_hi)); // R4
endmodule

// File: tb/wp_guard_tb.sv
module wp_guard_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [23:0] tag;
    logic [2:0]  lvl;
    logic        sec;
    logic        bot;
    logic        inv;
    logic [23:0] addr;
    logic [1:0]  op;
    logic        rej;
    logic        vld;
    logic [23:0] lo;
    logic [23:0] hi;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{"R1 ", 3'd0, 1'b0, 1'b0, 1'b0, 24'h3FF000, 2'd1, 1'b0, 1'b0, 24'h000000, 24'h000000},
    '{"R2 ", 3'd7, 1'b1, 1'b1, 1'b0, 24'h000000, 2'd0, 1'b1, 1'b1, 24'h000000, 24'h3FFFFF},
    '{"R3 ", 3'd6, 1'b0, 1'b0, 1'b0, 24'h1FFF00, 2'd0, 1'b0, 1'b1, 24'h200000, 24'h3FFFFF},
    '{"R8 ", 3'd6, 1'b0, 1'b0, 1'b0, 24'h200000, 2'd0, 1'b1, 1'b1, 24'h200000, 24'h3FFFFF},
    '{"R3 ", 3'd1, 1'b0, 1'b0, 1'b0, 24'h3EFFFF, 2'd2, 1'b0, 1'b1, 24'h3F0000, 24'h3FFFFF},
    '{"R4 ", 3'd1, 1'b0, 1'b1, 1'b0, 24'h00FFFF, 2'd0, 1'b1, 1'b1, 24'h000000, 24'h00FFFF},
    '{"R4 ", 3'd3, 1'b0, 1'b1, 1'b0, 24'h040000, 2'd2, 1'b0, 1'b1, 24'h000000, 24'h03FFFF},
    '{"R3 ", 3'd5, 1'b0, 1'b0, 1'b0, 24'h2F1234, 2'd2, 1'b0, 1'b1, 24'h300000, 24'h3FFFFF},
    '{"R5 ", 3'd1, 1'b1, 1'b0, 1'b0, 24'h3FE800, 2'd1, 1'b0, 1'b1, 24'h3FF000, 24'h3FFFFF},
    '{"R5 ", 3'd2, 1'b1, 1'b0, 1'b0, 24'h3FE800, 2'd1, 1'b1, 1'b1, 24'h3FE000, 24'h3FFFFF},
    '{"R5 ", 3'd3, 1'b1, 1'b1, 1'b0, 24'h004000, 2'd0, 1'b0, 1'b1, 24'h000000, 24'h003FFF},
    '{"R5 ", 3'd4, 1'b1, 1'b1, 1'b0, 24'h007F00, 2'd0, 1'b1, 1'b1, 24'h000000, 24'h007FFF},
    '{"R5 ", 3'd6, 1'b1, 1'b0, 1'b0, 24'h3F7F00, 2'd0, 1'b0, 1'b1, 24'h3F8000, 24'h3FFFFF},
    '{"R5 ", 3'd5, 1'b1, 1'b0, 1'b0, 24'h3F8000, 2'd0, 1'b1, 1'b1, 24'h3F8000, 24'h3FFFFF},
    '{"R6 ", 3'd1, 1'b1, 1'b0, 1'b1, 24'h3FF000, 2'd1, 1'b0, 1'b1, 24'h000000, 24'h3FEFFF},
    '{"R6 ", 3'd1, 1'b1, 1'b0, 1'b1, 24'h3FEFFF, 2'd0, 1'b1, 1'b1, 24'h000000, 24'h3FEFFF},
    '{"R6 ", 3'd0, 1'b0, 1'b0, 1'b1, 24'h3FFF00, 2'd0, 1'b1, 1'b1, 24'h000000, 24'h3FFFFF},
    '{"R9 ", 3'd7, 1'b0, 1'b0, 1'b1, 24'h000000, 2'd3, 1'b0, 1'b0, 24'h000000, 24'h000000},
    '{"R6 ", 3'd6, 1'b0, 1'b1, 1'b1, 24'h1FFFFF, 2'd1, 1'b0, 1'b1, 24'h200000, 24'h3FFFFF},
    '{"R9 ", 3'd1, 1'b0, 1'b0, 1'b0, 24'h000000, 2'd3, 1'b1, 1'b1, 24'h3F0000, 24'h3FFFFF},
    '{"R7 ", 3'd1, 1'b0, 1'b0, 1'b0, 24'hC00000, 2'd0, 1'b0, 1'b1, 24'h3F0000, 24'h3FFFFF},
    '{"R7 ", 3'd1, 1'b0, 1'b0, 1'b0, 24'hFFFF00, 2'd0, 1'b1, 1'b1, 24'h3F0000, 24'h3FFFFF}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [2:0]  prot_lvl = '0;
  logic        gran_sect = 1'b0, from_bottom = 1'b0, invert = 1'b0;
  logic [23:0] addr = '0;
  logic [1:0]  op = '0;
  logic        grant, reject, range_valid;
  logic [23:0] range_lo, range_hi;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wp_guard dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .prot_lvl(prot_lvl),
    .gran_sect(gran_sect), .from_bottom(from_bottom), .invert(invert),
    .addr(addr), .op(op), .grant(grant), .reject(reject),
    .range_valid(range_valid), .range_lo(range_lo), .range_hi(range_hi)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    prot_lvl = v.lvl; gran_sect = v.sec; from_bottom = v.bot; invert = v.inv;
    addr = v.addr; op = v.op;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL R10 watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // reset state (R10)
    repeat (3) @(negedge clk);
    chk("R10 reset grant", 32'(grant), 32'd0);
    chk("R10 reset reject", 32'(reject), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 idle grant", 32'(grant), 32'd0);
    chk("R10 idle reject", 32'(reject), 32'd0);

    // vector table: R1..R9
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      apply(VECS[i]);
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      chk($sformatf("%s vec %0d reject", VECS[i].tag, i), 32'(reject), 32'(VECS[i].rej));
      chk($sformatf("%s vec %0d grant", VECS[i].tag, i), 32'(grant), 32'(!VECS[i].rej));
      chk($sformatf("%s vec %0d range_valid", VECS[i].tag, i), 32'(range_valid), 32'(VECS[i].vld));
      if (VECS[i].vld) begin
        chk($sformatf("%s vec %0d range_lo", VECS[i].tag, i), 32'(range_lo), 32'(VECS[i].lo));
        chk($sformatf("%s vec %0d range_hi", VECS[i].tag, i), 32'(range_hi), 32'(VECS[i].hi));
      end
    end

    // R10: back-to-back strobes give one pulse each, then silence
    @(negedge clk);
    apply(VECS[3]);
    req = 1'b1;
    @(negedge clk);
    chk("R10 first of pair reject", 32'(reject), 32'd1);
    apply(VECS[2]);
    @(negedge clk);
    req = 1'b0;
    chk("R10 second of pair grant", 32'(grant), 32'd1);
    chk("R10 second of pair reject", 32'(reject), 32'd0);
    @(negedge clk);
    chk("R10 no stray grant", 32'(grant), 32'd0);
    chk("R10 no stray reject", 32'(reject), 32'd0);

    // R2: all-protect ignores granularity and top/bottom in every combination
    for (int k = 0; k < 4; k++) begin
      prot_lvl = 3'd7; invert = 1'b0; gran_sect = k[0]; from_bottom = k[1];
      addr = 24'h123400; op = 2'd0;
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      chk($sformatf("R2 combo %0d reject", k), 32'(reject), 32'd1);
      chk($sformatf("R2 combo %0d range_hi", k), 32'(range_hi), 32'h3FFFFF);
    end

    // R10: reset in the cycle after a strobe clears the pulse
    @(negedge clk);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R10 reset clears pulse", 32'(grant | reject), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule